// File: doc/BRIEF.md
# BPSK Carrier Modulator

This block produces a sampled sine carrier and applies binary phase-shift keying to it. A phase accumulator advances by a fixed increment every clock. The top bits of the accumulator address a sine table in on-chip memory that holds one full carrier period. The table output is either passed through or negated in two's complement, and the result leaves the block as a signed 16-bit sample stream. With an 80 MHz clock and the default increment, the carrier is 1 MHz.

A serial data bit arrives with a strobe. In level mode the strobed bit directly requests the upright or inverted carrier. In differential mode the carrier polarity toggles each time the strobed bit differs from the previous strobed bit. A requested polarity is held pending until the accumulator wraps, so every phase reversal lands on a carrier zero crossing.

A first-order sigma-delta stage turns the sample stream into a one-bit pulse density at the clock rate. That bit can drive a pin directly, and an external RC network is enough to rebuild the analogue carrier.

Top module: `bpsk_modulator`

## Requirements
- R1: On each clock out of reset, the 32-bit phase accumulator advances by PHASE_INC modulo 2^32. The default PHASE_INC is 53687091, which is round(2^32/80) and gives a carrier at 1/80 of the clock rate.
- R2: The sine table has 256 entries and is addressed by accumulator bits [31:24]. Entry n holds round(32767*sin(2*pi*n/256)), with halves rounded away from zero.
- R3: sampleOut is registered. The value it shows two clock edges after the accumulator holds phase P is entry P[31:24] of the table, under the polarity in force.
- R4: Inversion is the two's-complement negation of the table sample. A negated value of -32768 saturates to +32767, so sampleOut never equals -32768.
- R5: Level mode (diffMode=0): a strobe with dataBit=1 requests the inverted carrier, and a strobe with dataBit=0 requests the upright carrier.
- R6: Differential mode (diffMode=1): a strobe whose dataBit differs from the previously strobed bit toggles the requested polarity. A strobe with an equal bit leaves it unchanged. The previously strobed bit is tracked in both modes.
- R7: A requested polarity takes effect only from the first sample read after the accumulator wraps past zero. All samples of one carrier cycle share one polarity, and polarity is never changed by jumping the accumulator.
- R8: The sigma-delta stage keeps a 17-bit integrator. Each clock it loads the integrator's low 16 bits plus the current sampleOut with its sign bit inverted (offset binary). sdOut is integrator bit 16.
- R9: Synchronous reset clears the accumulator, the requested and applied polarity, the last strobed bit, the pipeline registers and the integrator. While reset is held and on the first edge after it is released, sampleOut is 0 and sdOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (80 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| dataBit | input | 1 | Serial data bit |
| dataStrobe | input | 1 | Qualifies dataBit for one cycle |
| diffMode | input | 1 | 0 = level keying, 1 = differential keying |
| sampleOut | output | 16 | Signed modulated carrier sample |
| sdOut | output | 1 | First-order sigma-delta bitstream of sampleOut |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 256-entry 16-bit table, an increment of 53687091 and the sigma-delta stage enabled. At 80 clocks per carrier period a short run crosses the accumulator wrap many times. Random strobes therefore land at every phase and in both keying modes, and they exercise the pending-until-wrap rule together with the exact integrator sequence. Because the full-scale table never holds -32768, the saturation path cannot be reached with these parameters and is guarded only by the output assertion.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic negate;
  } bpsk_ctl_t;

  // datapath -> control strobes
  typedef struct packed {
    logic cycleStart;
  } bpsk_stat_t;

endpackage

// File: rtl/bpsk_sine_rom.sv
module bpsk_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] q
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam int  AMPL  = (1 << (DATA_W - 1)) - 1;
  localparam real PI    = 3.14159265358979323846;

  logic signed [DATA_W-1:0] romMem [DEPTH];

  // one full period, rounded half away from zero
  initial begin
    for (int n = 0; n < DEPTH; n++) begin
      real x;
      int  v;
      x = real'(AMPL) * $sin(2.0 * PI * real'(n) / real'(DEPTH));
      v = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
      romMem[n] = DATA_W'(v);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= romMem[addr];
  end

endmodule

// File: rtl/bpsk_sigma_delta.sv
module bpsk_sigma_delta #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] sampleIn,
  output logic                bitOut
);
  logic [W:0]   integ;
  logic [W-1:0] offsetIn;

  assign offsetIn = {~sampleIn[W-1], sampleIn[W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) integ <= '0;
    else     integ <= {1'b0, integ[W-1:0]} + {1'b0, offsetIn};
  end

  assign bitOut = integ[W];

  // R8: after a carry the residue is below the input just added
  a_r8_carry_residue: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bitOut) |-> (integ[W-1:0] < $past(offsetIn)));

endmodule

// File: rtl/bpsk_control.sv
module bpsk_control
  import bpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dataBit,
  input  logic       dataStrobe,
  input  logic       diffMode,
  input  bpsk_stat_t stat,
  output bpsk_ctl_t  ctl
);
  logic pending;   // requested polarity
  logic lastBit;   // previously strobed data bit
  logic pol;       // applied polarity

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      lastBit <= 1'b0;
      pol     <= 1'b0;
    end else begin
      if (dataStrobe) begin
        lastBit <= dataBit;
        if (diffMode) pending <= pending ^ (dataBit ^ lastBit);
        else          pending <= dataBit;
      end
      if (stat.cycleStart) pol <= pending;
    end
  end

  assign ctl.negate = pol;

  // R5: level mode request follows the strobed bit
  a_r5_level_request: assert property (@(posedge clk) disable iff (rst)
    (dataStrobe && !diffMode) |=> (pending == $past(dataBit)));

  // R6: a changed bit toggles the request in differential mode
  a_r6_diff_toggle: assert property (@(posedge clk) disable iff (rst)
    (dataStrobe && diffMode && (dataBit != lastBit)) |=> (pending != $past(pending)));

  // R6: an equal bit holds the request in differential mode
  a_r6_diff_hold: assert property (@(posedge clk) disable iff (rst)
    (dataStrobe && diffMode && (dataBit == lastBit)) |=> $stable(pending));

  // R7: applied polarity moves only on a carrier cycle start
  a_r7_flip_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (pol != $past(pol))) |-> $past(stat.cycleStart));

endmodule

// File: rtl/bpsk_datapath.sv
module bpsk_datapath
  import bpsk_pkg::*;
#(
  parameter int                    PHASE_W   = 32,
  parameter int                    ADDR_W    = 8,
  parameter int                    SAMPLE_W  = 16,
  parameter logic [PHASE_W-1:0]    PHASE_INC = 32'd53687091,
  parameter bit                    SD_ENABLE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  bpsk_ctl_t                  ctl,
  output bpsk_stat_t                 stat,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       sdOut
);
  localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [PHASE_W-1:0]         phaseAcc;
  logic [PHASE_W-1:0]         phaseNext;
  logic                       carry;
  logic                       wrapQ;
  logic signed [SAMPLE_W-1:0] romQ;
  logic signed [SAMPLE_W-1:0] negQ;
  logic signed [SAMPLE_W-1:0] sampleQ;

  assign {carry, phaseNext} = {1'b0, phaseAcc} + {1'b0, PHASE_INC};

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      wrapQ    <= 1'b0;
    end else begin
      phaseAcc <= phaseNext;
      wrapQ    <= carry;
    end
  end

  bpsk_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(SAMPLE_W)) rom_i (
    .clk  (clk),
    .rst  (rst),
    .addr (phaseAcc[PHASE_W-1 -: ADDR_W]),
    .q    (romQ)
  );

  // the sample read in the cycle after a wrap is the first of a new period
  assign stat.cycleStart = wrapQ;

  assign negQ = (romQ == S_MIN) ? S_MAX : -romQ;

  always_ff @(posedge clk) begin
    if (rst)             sampleQ <= '0;
    else if (ctl.negate) sampleQ <= negQ;
    else                 sampleQ <= romQ;
  end

  assign sampleOut = sampleQ;

  generate
    if (SD_ENABLE) begin : g_sd
      bpsk_sigma_delta #(.W(SAMPLE_W)) sd_i (
        .clk      (clk),
        .rst      (rst),
        .sampleIn (sampleQ),
        .bitOut   (sdOut)
      );
    end else begin : g_nosd
      assign sdOut = 1'b0;
    end
  endgenerate

  // R1: accumulator steps by the increment each cycle
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phaseAcc == $past(phaseAcc) + PHASE_INC));

  // R4: the output never reaches the most negative code
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sampleOut != S_MIN);

  // R9: the first sample after reset is zero
  a_r9_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sampleOut == '0));

endmodule

// File: rtl/bpsk_modulator.sv
module bpsk_modulator
  import bpsk_pkg::*;
#(
  parameter int                 PHASE_W   = 32,
  parameter int                 ADDR_W    = 8,
  parameter int                 SAMPLE_W  = 16,
  parameter logic [PHASE_W-1:0] PHASE_INC = 32'd53687091,
  parameter bit                 SD_ENABLE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dataBit,
  input  logic                dataStrobe,
  input  logic                diffMode,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sdOut
);
  bpsk_ctl_t                  ctl;
  bpsk_stat_t                 stat;
  logic signed [SAMPLE_W-1:0] sampleS;

  bpsk_control control_i (
    .clk        (clk),
    .rst        (rst),
    .dataBit    (dataBit),
    .dataStrobe (dataStrobe),
    .diffMode   (diffMode),
    .stat       (stat),
    .ctl        (ctl)
  );

  bpsk_datapath #(
    .PHASE_W   (PHASE_W),
    .ADDR_W    (ADDR_W),
    .SAMPLE_W  (SAMPLE_W),
    .PHASE_INC (PHASE_INC),
    .SD_ENABLE (SD_ENABLE)
  ) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .stat      (stat),
    .sampleOut (sampleS),
    .sdOut     (sdOut)
  );

  assign sampleOut = sampleS;

endmodule

// File: tb/bpsk_modulator_tb.sv
module bpsk_modulator_tb_top;
  localparam logic [31:0] INC = 32'd53687091;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dataBit = 1'b0;
  logic        dataStrobe = 1'b0;
  logic        diffMode = 1'b0;
  logic [15:0] sampleOut;
  logic        sdOut;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0]        mAcc;
  logic signed [15:0] mRomQ;
  logic               mWrapQ;
  logic               mPend;
  logic               mLast;
  logic               mPol;
  logic signed [15:0] mSample;
  logic [16:0]        mSd;

  always #2 clk = ~clk;

  bpsk_modulator dut_i (
    .clk        (clk),
    .rst        (rst),
    .dataBit    (dataBit),
    .dataStrobe (dataStrobe),
    .diffMode   (diffMode),
    .sampleOut  (sampleOut),
    .sdOut      (sdOut)
  );

  function automatic logic signed [15:0] sineEntry(input logic [7:0] idx);
    real x;
    int  v;
    x = 32767.0 * $sin(2.0 * PI * real'(idx) / 256.0);
    v = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
    return 16'(v);
  endfunction

  function automatic logic signed [15:0] invert(input logic signed [15:0] s);
    return (s == -16'sd32768) ? 16'sd32767 : -s;
  endfunction

  task automatic check(input logic ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic modelStep();
    logic [32:0]        sum;
    logic signed [15:0] nSample;
    logic [16:0]        nSd;
    logic               nPend;
    logic               nPol;
    if (rst) begin
      mAcc = '0; mRomQ = '0; mWrapQ = 1'b0; mPend = 1'b0;
      mLast = 1'b0; mPol = 1'b0; mSample = '0; mSd = '0;
    end else begin
      sum     = {1'b0, mAcc} + {1'b0, INC};
      nSample = mPol ? invert(mRomQ) : mRomQ;
      nSd     = {1'b0, mSd[15:0]} + {1'b0, ~mSample[15], mSample[14:0]};
      nPend   = mPend;
      if (dataStrobe) nPend = diffMode ? (mPend ^ (dataBit ^ mLast)) : dataBit;
      nPol    = mWrapQ ? mPend : mPol;
      if (dataStrobe) mLast = dataBit;
      mRomQ   = sineEntry(mAcc[31:24]);
      mWrapQ  = sum[32];
      mAcc    = sum[31:0];
      mPend   = nPend;
      mPol    = nPol;
      mSample = nSample;
      mSd     = nSd;
    end
  endtask

  // one clock: inputs already applied; step model and compare at negedge
  task automatic cycle();
    @(negedge clk);
    modelStep();
    check(sampleOut == mSample, "R1 R2 R3 R5 R6 R7 sampleOut",
          int'($signed(sampleOut)), int'(mSample));
    check(sampleOut != 16'h8000, "R4 no -32768", int'($signed(sampleOut)), 32767);
    check(sdOut == mSd[16], "R8 sdOut", int'(sdOut), int'(mSd[16]));
  endtask

  task automatic randomRun(input int n, input logic mode);
    diffMode = mode;
    for (int i = 0; i < n; i++) begin
      dataStrobe = (($urandom % 8) == 0);
      dataBit    = 1'($urandom);
      cycle();
    end
    dataStrobe = 1'b0;
  endtask

  task automatic doReset(input int n);
    rst = 1'b1;
    dataStrobe = 1'b0;
    for (int i = 0; i < n; i++) begin
      cycle();
      check(sampleOut == 16'h0 && sdOut == 1'b0, "R9 outputs in reset",
            int'(sampleOut), 0);
    end
    rst = 1'b0;
    cycle();
    check(sampleOut == 16'h0, "R9 first sample after reset", int'(sampleOut), 0);
  endtask

  initial begin
    int peak;
    void'($urandom(32'd20517));
    doReset(4);

    // R2: upright carrier reaches a near full-scale positive peak
    peak = 0;
    for (int i = 0; i < 80; i++) begin
      cycle();
      if (int'($signed(sampleOut)) > peak) peak = int'($signed(sampleOut));
    end
    check(peak == int'(sineEntry(8'd63)) || peak == int'(sineEntry(8'd64)),
          "R2 positive peak", peak, 32767);

    // R5/R7: level request mid cycle waits for the wrap
    diffMode = 1'b0; dataBit = 1'b1; dataStrobe = 1'b1;
    cycle();
    dataStrobe = 1'b0;
    for (int i = 0; i < 200; i++) cycle();

    // R6: equal bits in differential mode hold polarity
    diffMode = 1'b1; dataBit = 1'b1;
    for (int i = 0; i < 160; i++) begin
      dataStrobe = (i % 20 == 0);
      cycle();
    end
    // R6: alternating bits toggle every strobe
    for (int i = 0; i < 320; i++) begin
      dataStrobe = (i % 40 == 0);
      dataBit    = 1'((i / 40) % 2);
      cycle();
    end
    dataStrobe = 1'b0;

    randomRun(3000, 1'b0);
    randomRun(3000, 1'b1);
    doReset(3);
    randomRun(1500, 1'b1);
    randomRun(1500, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule